// File: doc/BRIEF.md
# Serial Memory Slave Front End

This block sits between a four-wire serial bus and a byte-wide nonvolatile store of 512 locations. The bus uses mode 0: the serial clock idles low, data in is taken on rising clock edges, data out changes on falling edges, and bits travel most significant first. An active-low chip select frames each access. The block samples all bus inputs with a fast system clock, which lets it work with an ordinary synchronous array port and write controller.

Each access begins with an instruction byte. For reads and writes, the ninth address bit sits in bit 3 of that byte, and the low eight address bits follow in a second byte. A read streams bytes from consecutive locations for as long as the host keeps clocking. The address wraps from the top of the array back to zero. A write sends each received data byte to the write controller with its address. Short instructions produce one-cycle strobes for the write controller: set or clear the write latch, write the status byte, or stream the status byte out.

An active-low pause input freezes the transaction in place. While paused, the block ignores clock and data-in transitions and turns the output off. When the pause is released, the transfer continues where it stopped. Chip select is still observed during a pause.

Top module: `spi_nvm_slave`

## Requirements
- R1: After reset, so_oe is 0 and no strobe output is high until a complete instruction byte has been received.
- R2: Instruction 0x03, with address bit 8 placed in bit 3 (0x03 or 0x0B), followed by the low address byte, issues a one-cycle mem_rd_stb with mem_addr set to that address. The block takes mem_rdata one clock after the strobe cycle. It shifts that byte out MSB first on so, and the first bit appears on the falling edge that follows the last address bit.
- R3: While clocking continues, a read returns one byte per eight clocks from the next location. After address 511 it returns address 0.
- R4: Instruction 0x02, with address bit 8 in bit 3 (0x02 or 0x0A), followed by the address byte, makes each complete data byte raise wr_byte_stb for one cycle. wr_data holds the byte and mem_addr holds its address. mem_addr then rises by one.
- R5: Instruction 0x06 raises wel_set_stb once, and instruction 0x04 raises wel_clr_stb once. At most one strobe output is high in any cycle.
- R6: Instruction 0x05 shifts status_in out on so, MSB first, and repeats it for each further byte clocked.
- R7: Instruction 0x01 followed by one byte raises sr_wr_stb once, with that byte on wr_data. Any later bytes in the same frame are ignored.
- R8: Raising cs_n at any point ends the transaction and discards a partial byte. The next frame starts with a fresh instruction byte.
- R9: While pause_n is low, clock and data-in transitions have no effect on the transfer. When pause_n returns high, the transfer resumes at the bit where it stopped.
- R10: so_oe is 1 only while cs_n is low, pause_n is high and a read or status transfer is in progress. Otherwise it is 0.
- R11: An instruction byte with any other value causes no strobe and leaves so_oe at 0 until cs_n goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, idle low |
| si | input | 1 | Serial data in |
| pause_n | input | 1 | Active-low pause |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so |
| mem_addr | output | 9 | Address for array reads and byte writes |
| mem_rd_stb | output | 1 | One-cycle array read request |
| mem_rdata | input | 8 | Array data, valid one cycle after the read strobe |
| wr_byte_stb | output | 1 | One-cycle byte write request |
| wr_data | output | 8 | Byte for a data or status write |
| wel_set_stb | output | 1 | Write-latch set request |
| wel_clr_stb | output | 1 | Write-latch clear request |
| sr_wr_stb | output | 1 | Status write request |
| status_in | input | 8 | Status byte to stream out |

## Verification
Reads are tried at a low-half address and at the top of the array. The low-half read shows that the address byte is assembled correctly. The read at 0x1FE with bit 8 set in the instruction checks that bit 3 is decoded and that the address wraps to zero. Pauses are placed inside the address byte and inside a data byte, with clock and data toggled during the pause. A resulting byte that is wrong or shifted separates a real freeze from a missed or phantom edge. Aborted frames, unknown instructions and the short instructions are each followed by a known access, which shows that the abort or the ignored byte left no stale state behind.

// File: rtl/spi_nvm_slave.sv
module spi_nvm_slave #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       si,
  input  logic       pause_n,
  output logic       so,
  output logic       so_oe,
  output logic [8:0] mem_addr,
  output logic       mem_rd_stb,
  input  logic [7:0] mem_rdata,
  output logic       wr_byte_stb,
  output logic [7:0] wr_data,
  output logic       wel_set_stb,
  output logic       wel_clr_stb,
  output logic       sr_wr_stb,
  input  logic [7:0] status_in
);
  localparam int S = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  typedef enum logic [2:0] {
    ST_CMD, ST_ADDR, ST_READ, ST_WDATA, ST_RDSR, ST_WRSR, ST_SKIP
  } st_t;

  logic [S-1:0] cs_q, sck_q, si_q, pn_q;
  logic         cs_s, sck_s, si_s, pn_s, sck_d;
  logic         active, rise, fall, byte_done, tx_phase;
  logic [7:0]   sh, byte_in, tx;
  logic [2:0]   bitcnt, outcnt;
  logic         rd_op, a8, rd_pend;
  st_t          st;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q  <= '1;
      sck_q <= '0;
      si_q  <= '0;
      pn_q  <= '1;
    end else begin
      cs_q  <= {cs_q[S-2:0], cs_n};
      sck_q <= {sck_q[S-2:0], sck};
      si_q  <= {si_q[S-2:0], si};
      pn_q  <= {pn_q[S-2:0], pause_n};
    end

  assign cs_s      = cs_q[S-1];
  assign sck_s     = sck_q[S-1];
  assign si_s      = si_q[S-1];
  assign pn_s      = pn_q[S-1];
  assign active    = ~cs_s & pn_s;
  assign rise      = active & sck_s & ~sck_d;
  assign fall      = active & ~sck_s & sck_d;
  assign byte_in   = {sh[6:0], si_s};
  assign byte_done = rise && (bitcnt == 3'd7);
  assign tx_phase  = (st == ST_READ) || (st == ST_RDSR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_d       <= 1'b0;
      st          <= ST_CMD;
      sh          <= '0;
      tx          <= '0;
      bitcnt      <= '0;
      outcnt      <= '0;
      rd_op       <= 1'b0;
      a8          <= 1'b0;
      rd_pend     <= 1'b0;
      so          <= 1'b0;
      so_oe       <= 1'b0;
      mem_addr    <= '0;
      mem_rd_stb  <= 1'b0;
      wr_byte_stb <= 1'b0;
      wr_data     <= '0;
      wel_set_stb <= 1'b0;
      wel_clr_stb <= 1'b0;
      sr_wr_stb   <= 1'b0;
    end else begin
      sck_d       <= sck_s;
      mem_rd_stb  <= 1'b0;
      wr_byte_stb <= 1'b0;
      wel_set_stb <= 1'b0;
      wel_clr_stb <= 1'b0;
      sr_wr_stb   <= 1'b0;
      rd_pend     <= mem_rd_stb;
      so_oe       <= active & tx_phase;
      if (rd_pend) tx <= mem_rdata;
      if (wr_byte_stb) mem_addr <= mem_addr + 9'd1;
      if (cs_s) begin
        st     <= ST_CMD;
        bitcnt <= '0;
        outcnt <= '0;
        so     <= 1'b0;
      end else begin
        if (rise) begin
          sh     <= byte_in;
          bitcnt <= bitcnt + 3'd1;
        end
        if (byte_done) begin
          case (st)
            ST_CMD: begin
              if ((byte_in & 8'hF7) == 8'h03) begin
                rd_op <= 1'b1;
                a8    <= byte_in[3];
                st    <= ST_ADDR;
              end else if ((byte_in & 8'hF7) == 8'h02) begin
                rd_op <= 1'b0;
                a8    <= byte_in[3];
                st    <= ST_ADDR;
              end else if (byte_in == 8'h06) begin
                wel_set_stb <= 1'b1;
                st          <= ST_SKIP;
              end else if (byte_in == 8'h04) begin
                wel_clr_stb <= 1'b1;
                st          <= ST_SKIP;
              end else if (byte_in == 8'h05) begin
                tx     <= status_in;
                outcnt <= '0;
                st     <= ST_RDSR;
              end else if (byte_in == 8'h01) begin
                st <= ST_WRSR;
              end else begin
                st <= ST_SKIP;
              end
            end
            ST_ADDR: begin
              mem_addr <= {a8, byte_in};
              if (rd_op) begin
                mem_rd_stb <= 1'b1;
                outcnt     <= '0;
                st         <= ST_READ;
              end else begin
                st <= ST_WDATA;
              end
            end
            ST_WDATA: begin
              wr_byte_stb <= 1'b1;
              wr_data     <= byte_in;
            end
            ST_WRSR: begin
              sr_wr_stb <= 1'b1;
              wr_data   <= byte_in;
              st        <= ST_SKIP;
            end
            default: ;
          endcase
        end
        if (fall && tx_phase) begin
          so     <= tx[7];
          tx     <= {tx[6:0], 1'b0};
          outcnt <= outcnt + 3'd1;
          if (outcnt == 3'd7) begin
            if (st == ST_READ) begin
              mem_addr   <= mem_addr + 9'd1;
              mem_rd_stb <= 1'b1;
            end else begin
              tx <= status_in;
            end
          end
        end
      end
    end
endmodule

module spi_nvm_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_s,
  input logic       pn_s,
  input logic [2:0] st,
  input logic [2:0] bitcnt,
  input logic       so_oe,
  input logic [8:0] mem_addr,
  input logic       mem_rd_stb,
  input logic       wr_byte_stb,
  input logic       wel_set_stb,
  input logic       wel_clr_stb,
  input logic       sr_wr_stb
);
  assert_rd_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_stb |=> !mem_rd_stb);
  assert_wr_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_byte_stb |=> (mem_addr == $past(mem_addr) + 9'd1));
  assert_strobe_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_stb, wr_byte_stb, wel_set_stb, wel_clr_stb, sr_wr_stb}));
  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (st == 3'd0 && bitcnt == 3'd0));
  assert_pause_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pn_s && !cs_s) |=> ($stable(st) && $stable(bitcnt)));
  assert_oe_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s || !pn_s) |=> !so_oe);
endmodule

bind spi_nvm_slave spi_nvm_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .pn_s(pn_s), .st(st), .bitcnt(bitcnt),
  .so_oe(so_oe), .mem_addr(mem_addr), .mem_rd_stb(mem_rd_stb),
  .wr_byte_stb(wr_byte_stb), .wel_set_stb(wel_set_stb),
  .wel_clr_stb(wel_clr_stb), .sr_wr_stb(sr_wr_stb)
);

// File: tb/spi_nvm_slave_tb.sv
module spi_nvm_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0, pause_n = 1;
  logic so, so_oe, mem_rd_stb, wr_byte_stb, wel_set_stb, wel_clr_stb, sr_wr_stb;
  logic [8:0] mem_addr;
  logic [7:0] mem_rdata = 0, wr_data, status_in = 8'h8C, rx;
  int tests = 0, fails = 0, n_rd = 0, n_wr = 0, n_set = 0, n_clr = 0, n_sr = 0;
  logic [8:0] wa [0:3];
  logic [7:0] wd [0:3];
  logic [7:0] srd;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_nvm_slave dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .pause_n(pause_n),
    .so(so), .so_oe(so_oe), .mem_addr(mem_addr), .mem_rd_stb(mem_rd_stb),
    .mem_rdata(mem_rdata), .wr_byte_stb(wr_byte_stb), .wr_data(wr_data),
    .wel_set_stb(wel_set_stb), .wel_clr_stb(wel_clr_stb), .sr_wr_stb(sr_wr_stb),
    .status_in(status_in)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37) + 11 + ((a >> 8) * 5));
  endfunction

  always @(posedge clk) begin
    if (mem_rd_stb) begin
      mem_rdata <= pat(int'(mem_addr));
      n_rd <= n_rd + 1;
    end
    if (wr_byte_stb) begin
      if (n_wr < 4) begin
        wa[n_wr] <= mem_addr;
        wd[n_wr] <= wr_data;
      end
      n_wr <= n_wr + 1;
    end
    if (wel_set_stb) n_set <= n_set + 1;
    if (wel_clr_stb) n_clr <= n_clr + 1;
    if (sr_wr_stb) begin
      n_sr <= n_sr + 1;
      srd  <= wr_data;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) si = v[7-i];
      wait_clk(HALF);
      rx = {rx[6:0], so};
      sck = 1;
      wait_clk(HALF);
      sck = 0;
    end
  endtask

  task automatic send_byte(input logic [7:0] v);
    rx = 0;
    send_bits(v, 8);
  endtask

  task automatic frame_start;
    @(negedge clk) cs_n = 0;
    wait_clk(4);
  endtask

  task automatic frame_end;
    wait_clk(HALF);
    cs_n = 1;
    wait_clk(8);
  endtask

  task automatic t_reset;
    chk("R1 so_oe after reset", so_oe, 0);
    chk("R1 no strobes after reset", n_rd + n_wr + n_set + n_clr + n_sr, 0);
  endtask

  task automatic t_read_low;
    frame_start();
    send_byte(8'h03);
    send_byte(8'h5A);
    chk("R2 read strobe count", n_rd, 1);
    send_byte(8'h00);
    chk("R2 read byte 0x05A", rx, pat(9'h05A));
    send_byte(8'h00);
    chk("R3 sequential 0x05B", rx, pat(9'h05B));
    frame_end();
  endtask

  task automatic t_read_wrap;
    frame_start();
    send_byte(8'h0B);
    send_byte(8'hFE);
    send_byte(8'h00);
    chk("R2 read byte 0x1FE", rx, pat(9'h1FE));
    send_byte(8'h00);
    chk("R3 read byte 0x1FF", rx, pat(9'h1FF));
    send_byte(8'h00);
    chk("R3 wrap to 0x000", rx, pat(0));
    frame_end();
  endtask

  task automatic t_write;
    int n0;
    n0 = n_wr;
    frame_start();
    send_byte(8'h0A);
    send_byte(8'h30);
    send_byte(8'hA5);
    send_byte(8'h3C);
    frame_end();
    chk("R4 write strobe count", n_wr - n0, 2);
    chk("R4 first write addr", wa[0], 9'h130);
    chk("R4 first write data", wd[0], 8'hA5);
    chk("R4 second write addr", wa[1], 9'h131);
    chk("R4 second write data", wd[1], 8'h3C);
  endtask

  task automatic t_latch;
    frame_start(); send_byte(8'h06); frame_end();
    chk("R5 set strobe", n_set, 1);
    frame_start(); send_byte(8'h04); frame_end();
    chk("R5 clear strobe", n_clr, 1);
    chk("R5 set not repeated", n_set, 1);
  endtask

  task automatic t_status;
    frame_start();
    send_byte(8'h05);
    wait_clk(4);
    chk("R10 so_oe during status", so_oe, 1);
    send_byte(8'h00);
    chk("R6 status byte", rx, 8'h8C);
    send_byte(8'h00);
    chk("R6 status repeated", rx, 8'h8C);
    frame_end();
    chk("R10 so_oe after cs high", so_oe, 0);
  endtask

  task automatic t_wrsr;
    frame_start();
    send_byte(8'h01);
    send_byte(8'h9A);
    send_byte(8'h55);
    frame_end();
    chk("R7 status write count", n_sr, 1);
    chk("R7 status write data", srd, 8'h9A);
  endtask

  task automatic t_abort;
    frame_start();
    send_bits(8'h03, 4);
    frame_end();
    frame_start(); send_byte(8'h06); frame_end();
    chk("R8 partial byte discarded", n_set, 2);
    frame_start();
    send_byte(8'h03);
    send_bits(8'h10, 5);
    frame_end();
    frame_start();
    send_byte(8'h03);
    send_byte(8'h10);
    send_byte(8'h00);
    chk("R8 read after aborted address", rx, pat(9'h010));
    frame_end();
  endtask

  task automatic toggle_junk;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) si = ~si;
      sck = 1;
      wait_clk(HALF);
      sck = 0;
      wait_clk(HALF);
    end
  endtask

  task automatic t_pause;
    int r0;
    r0 = n_rd;
    frame_start();
    send_byte(8'h03);
    send_bits(8'h40, 3);
    @(negedge clk) pause_n = 0;
    wait_clk(4);
    toggle_junk();
    @(negedge clk) pause_n = 1;
    wait_clk(4);
    send_bits(8'h40 << 3, 5);
    chk("R9 one read after paused address", n_rd - r0, 1);
    rx = 0;
    send_bits(8'h00, 4);
    @(negedge clk) pause_n = 0;
    wait_clk(4);
    chk("R10 so_oe while paused", so_oe, 0);
    toggle_junk();
    @(negedge clk) pause_n = 1;
    wait_clk(4);
    chk("R10 so_oe after pause", so_oe, 1);
    send_bits(8'h00, 4);
    chk("R9 byte across pause", rx, pat(9'h040));
    send_byte(8'h00);
    chk("R9 next byte after pause", rx, pat(9'h041));
    frame_end();
  endtask

  task automatic t_unknown;
    int tot;
    tot = n_rd + n_wr + n_set + n_clr + n_sr;
    frame_start();
    send_byte(8'h07);
    wait_clk(4);
    chk("R11 so_oe after unknown", so_oe, 0);
    send_byte(8'h06);
    send_byte(8'h03);
    frame_end();
    chk("R11 no strobes", n_rd + n_wr + n_set + n_clr + n_sr, tot);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1;
    wait_clk(5);
    t_reset();
    t_read_low();
    t_read_wrap();
    t_write();
    t_latch();
    t_status();
    t_wrsr();
    t_abort();
    t_pause();
    t_unknown();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule